// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

This block takes one external interrupt pin, which can be asynchronous to the system clock, and turns it into a level request for a parent interrupt controller. Software picks one of four trigger conditions: low level, high level, falling edge or rising edge. A detected condition sets a pending flag. An enable flag decides whether that pending flag reaches the parent.

The block is programmed through three 32-bit registers on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. The control register holds the 2-bit trigger code. The pending register is cleared by writing a one to it. The enable register masks or unmasks the request. A parameter selects one of three address layouts, so the same RTL can be dropped into chips that place these registers differently.

To bring the block up, software first writes zero to enable and then writes one to pending bit 0. With the pin at its idle level, this sequence leaves the output deasserted.

Top module: `ext_irq_line`

## Requirements
- R1: After reset the control, pending and enable registers read 0 and `irq_out` is 0, with the pin held at its idle level (high).
- R2: The trigger code is held in control bits [1:0]. A write to control changes only those bits, and bits [31:2] always read 0.
- R3: The trigger codes are: 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge. In the edge modes, only the selected edge sets pending, and the opposite edge does not.
- R4: In the edge modes, pending bit 0 stays set until 1 is written to pending bit 0. Writing 0 to it has no effect.
- R5: In the level modes, pending is set on every cycle the active level is present. A clear written while the level is active leaves pending reading 1 on the next cycle. Once the level is gone, the clear takes effect and pending stays 0.
- R6: Enable bit 0 gates the request. `irq_out` takes the value of (pending AND enable) one clock after that value is present.
- R7: LAYOUT selects the register addresses:
  - 0: control 0x00, pending 0x04, enable 0x34.
  - 1: control 0x00, pending 0x04, enable 0x08.
  - 2: control 0x00, enable 0x04, pending 0x08.
- R8: Reads of any other address return 0. Writes to any other address change no register.
- R9: The pin passes through a two-flop synchronizer. A pin change made between clock edges shows up in pending after the third rising clock edge, and in `irq_out` after the fourth.
- R10: The bring-up sequence after reset (write 0 to enable, then write 1 to pending) leaves pending 0 and `irq_out` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| line_in | input | 1 | External interrupt pin, asynchronous |
| irq_out | output | 1 | Registered level request to the parent controller |

## Verification
All outputs have fixed latencies, counted from a change made between clock edges:
- A register write is visible on `bus_rdata` right after the edge that samples it.
- A pin change reaches pending after the third edge and `irq_out` after the fourth.
- A change to pending or enable reaches `irq_out` one edge later.

The bench drives all inputs on falling edges and samples outputs one nanosecond after a falling edge. It holds the read address fixed before moving the pin, so each stage of the pipeline is observed at the exact edge it is due, and one edge early as well. The sweep covers all three layouts and all four trigger codes, and probes every address of the 8-bit space for the unmapped-access rule.

// File: rtl/ext_irq_line.sv
`timescale 1ns/1ps
module ext_irq_line #(
  parameter int     LAYOUT    = 0,
  parameter int     ADDR_W    = 8,
  parameter logic   LINE_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              line_in,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] CTRL_OFF = '0;
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'((LAYOUT == 2) ? 8 : 4);
  localparam logic [ADDR_W-1:0] EN_OFF   = ADDR_W'((LAYOUT == 0) ? 52 : ((LAYOUT == 1) ? 8 : 4));

  localparam logic [1:0] TRIG_LOW  = 2'd0;
  localparam logic [1:0] TRIG_FALL = 2'd1;
  localparam logic [1:0] TRIG_HIGH = 2'd2;
  localparam logic [1:0] TRIG_RISE = 2'd3;

  logic [1:0] mode_q;
  logic       pend_q;
  logic       en_q;
  logic       sync1, sync2, prev;
  logic       hit;

  wire sel_ctrl = (bus_addr == CTRL_OFF);
  wire sel_pend = (bus_addr == PEND_OFF);
  wire sel_en   = (bus_addr == EN_OFF);
  wire wr_ctrl  = bus_we && sel_ctrl;
  wire wr_pend  = bus_we && sel_pend;
  wire wr_en    = bus_we && sel_en;
  wire rise     = sync2 && !prev;
  wire fall     = !sync2 && prev;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata[31:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= LINE_IDLE;
      sync2 <= LINE_IDLE;
      prev  <= LINE_IDLE;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    unique case (mode_q)
      TRIG_LOW:  hit = !sync2;
      TRIG_FALL: hit = fall;
      TRIG_HIGH: hit = sync2;
      default:   hit = rise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TRIG_LOW;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      if (wr_ctrl) mode_q <= bus_wdata[1:0];
      if (wr_en)   en_q   <= bus_wdata[0];
      if (hit)
        pend_q <= 1'b1;
      else if (wr_pend && bus_wdata[0])
        pend_q <= 1'b0;
      irq_out <= pend_q && en_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = {30'd0, mode_q};
    else if (sel_pend) bus_rdata = {31'd0, pend_q};
    else if (sel_en)   bus_rdata = {31'd0, en_q};
  end

  initial begin
    assert_layout_valid_R7: assert (LAYOUT >= 0 && LAYOUT <= 2)
      else $error("LAYOUT out of range");
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (bus_rdata[31:2] == 30'd0 || !sel_ctrl) && mode_q == $past(bus_wdata[1:0]));

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_RISE && sync2 && !prev) |=> pend_q);

  assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_FALL && !sync2 && prev) |=> pend_q);

  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && pend_q && !(wr_pend && bus_wdata[0])) |=> pend_q);

  assert_level_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_HIGH && sync2) |=> pend_q);

  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_out);

  assert_no_pend_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> !irq_out);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_ctrl || sel_pend || sel_en) |-> bus_rdata == 32'd0);

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(sel_ctrl || sel_pend || sel_en)) |=> $stable(en_q) && $stable(mode_q));

endmodule

// File: tb/ext_irq_line_bench.sv
`timescale 1ns/1ps
module ext_irq_line_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  we = '0;
  logic [31:0] wdata = '0;
  logic        line = 1'b1;
  logic [31:0] rdata [3];
  logic [2:0]  irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_line #(.LAYOUT(0)) u_ext_irq_line (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we[0]), .bus_wdata(wdata),
    .bus_rdata(rdata[0]), .line_in(line), .irq_out(irq[0]));
  ext_irq_line #(.LAYOUT(1)) u_ext_irq_line_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we[1]), .bus_wdata(wdata),
    .bus_rdata(rdata[1]), .line_in(line), .irq_out(irq[1]));
  ext_irq_line #(.LAYOUT(2)) u_ext_irq_line_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we[2]), .bus_wdata(wdata),
    .bus_rdata(rdata[2]), .line_in(line), .irq_out(irq[2]));

  function automatic logic [7:0] pend_a(int k);
    return (k == 2) ? 8'h08 : 8'h04;
  endfunction
  function automatic logic [7:0] en_a(int k);
    return (k == 0) ? 8'h34 : ((k == 1) ? 8'h08 : 8'h04);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int k, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 3'b000; we[k] = 1'b1;
    @(negedge clk);
    we = 3'b000;
    #1;
  endtask

  task automatic rd(logic [7:0] a, int k, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata[k];
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    for (int k = 0; k < 3; k++) begin
      rd(8'h00, k, v); chk("R1 ctrl", v, 0);
      rd(pend_a(k), k, v); chk("R1 pend", v, 0);
      rd(en_a(k), k, v); chk("R1 en", v, 0);
      chk("R1 irq", {31'd0, irq[k]}, 0);
      wr(k, en_a(k), 0);
      wr(k, pend_a(k), 1);
      idle(3);
      chk("R10 irq after bring-up", {31'd0, irq[k]}, 0);
      rd(pend_a(k), k, v); chk("R10 pend after bring-up", v, 0);
    end

    for (int k = 0; k < 3; k++) begin
      wr(k, en_a(k), 1);
      rd(en_a(k), k, v); chk("R7 enable address", v, 1);
      rd(pend_a(k), k, v); chk("R7 pending address", v, 0);
      rd(8'h00, k, v); chk("R7 control address", v, 0);
      for (int a = 0; a < 256; a++) begin
        if (a != 0 && a != int'(pend_a(k)) && a != int'(en_a(k))) begin
          rd(8'(a), k, v); chk("R8 unmapped read", v, 0);
          wr(k, 8'(a), 32'hFFFF_FFFF);
        end
      end
      rd(8'h00, k, v); chk("R8 ctrl untouched", v, 0);
      rd(pend_a(k), k, v); chk("R8 pend untouched", v, 0);
      rd(en_a(k), k, v); chk("R8 en untouched", v, 1);
    end

    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic act;
        act = (m >= 2);
        wr(k, en_a(k), 1);
        line = ~act;
        idle(4);
        wr(k, 8'h00, m);
        idle(4);
        wr(k, pend_a(k), 1);
        idle(2);
        rd(pend_a(k), k, v); chk("R3 quiet at idle level", v, 0);
        @(negedge clk); line = act; addr = pend_a(k);
        @(negedge clk); #1; chk("R9 pend after edge 1", rdata[k], 0);
        @(negedge clk); #1; chk("R9 pend after edge 2", rdata[k], 0);
        @(negedge clk); #1; chk("R3 R9 pend after edge 3", rdata[k], 1);
        chk("R9 irq after edge 3", {31'd0, irq[k]}, 0);
        @(negedge clk); #1; chk("R6 R9 irq after edge 4", {31'd0, irq[k]}, 1);
        if (m[0]) begin
          wr(k, pend_a(k), 0);
          rd(pend_a(k), k, v); chk("R4 write zero ignored", v, 1);
          wr(k, pend_a(k), 1);
          rd(pend_a(k), k, v); chk("R4 clear by one", v, 0);
          line = ~act;
          idle(5);
          rd(pend_a(k), k, v); chk("R3 opposite edge ignored", v, 0);
          chk("R3 irq stays low", {31'd0, irq[k]}, 0);
        end else begin
          wr(k, pend_a(k), 1);
          rd(pend_a(k), k, v); chk("R5 clear while active", v, 1);
          line = ~act;
          idle(5);
          rd(pend_a(k), k, v); chk("R5 held after level gone", v, 1);
          wr(k, pend_a(k), 1);
          idle(2);
          rd(pend_a(k), k, v); chk("R5 clear after level gone", v, 0);
        end
        line = act;
        idle(5);
        wr(k, en_a(k), 0);
        idle(2);
        chk("R6 masked irq", {31'd0, irq[k]}, 0);
        rd(pend_a(k), k, v); chk("R6 pend kept while masked", v, 1);
        wr(k, en_a(k), 1);
        chk("R6 irq one cycle late", {31'd0, irq[k]}, 0);
        @(negedge clk); #1;
        chk("R6 irq after unmask", {31'd0, irq[k]}, 1);
        line = ~act;
        idle(5);
        wr(k, pend_a(k), 1);
        idle(2);
        wr(k, 8'h00, 32'hFFFF_FFF0 | 32'(m));
        rd(8'h00, k, v); chk("R2 only bits 1:0 stored", v, 32'(m));
      end
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule